// File: doc/BRIEF.md
# AC-link Capture Slot Assembler

This block builds the parallel content of one AC-link input frame from a left/right pair of ADC samples and the state of the general-purpose pins. A 2-bit placement code chooses which of four slot pairs carries the audio pair. A routing bit chooses whether slot 12 carries the pin state or stays empty. The result is a 20-bit field for each of slots 1 to 12, plus the 16-bit tag word that is sent in slot 0. A downstream serializer shifts these values out over the frame.

Samples may arrive at any time between frames. The newest pair is held until the next frame boundary. The boundary is marked by a one-cycle `frame_start` pulse. All frame outputs are registered on that pulse and are held until the next one. The serializer therefore never sees a frame that mixes old and new placement, routing or data. Slot-12 pin routing should only be enabled when no other device on the link drives slot 12.

Top module: `aclink_capture_assembler`

## Requirements
- R1: While `rst_n` is low at a clock edge, every slot field and every tag bit becomes zero.
- R2: With placement code 00, the left sample goes to slot 3 and the right sample to slot 4.
- R3: With placement code 01, the left sample goes to slot 7 and the right sample to slot 8.
- R4: With placement code 10, the left sample goes to slot 6 and the right sample to slot 9.
- R5: With placement code 11, the left sample goes to slot 10 and the right sample to slot 11.
- R6: Every slot that carries neither the sample pair nor routed pin data is driven to all zeros, and its tag bit is 0.
- R7: The two sample slots carry data and have their tag bits set only if a sample pair arrived since the previous frame boundary. Otherwise both fields are zero and both tags are 0.
- R8: When `gpio_to_slot12` is 1, slot 12 carries `gpio_pins` in its low bits with the upper bits zero, and its tag bit is set. When it is 0, slot 12 is zero and its tag bit is 0.
- R9: The outputs change only on a clock edge that samples `frame_start` high. Placement code, routing bit, pins and samples are taken from that edge. Changes between boundaries have no effect until the next boundary.
- R10: In the tag word, bit 15-k is the valid flag of slot k (k = 1..12). Bit 15 is set when any slot flag is set. Bits 2:0 and the flags for slots 1 and 2 are always 0.
- R11: A sample pair presented in the same cycle as `frame_start` goes into that frame. If several pairs arrive between boundaries, the last one is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | One-cycle pulse marking a frame boundary |
| pair_code | input | 2 | Slot-pair placement code for the ADC samples |
| gpio_to_slot12 | input | 1 | 1 = send pin state in slot 12, 0 = slot 12 empty |
| gpio_pins | input | GPIO_W | Pin state, synchronous to clk |
| smp_valid | input | 1 | A new left/right sample pair is presented |
| smp_left | input | SMP_W | Left ADC sample |
| smp_right | input | SMP_W | Right ADC sample |
| slot_bus | output | 12*SLOT_W | Slot k field at bits [(k-1)*SLOT_W +: SLOT_W], k = 1..12 |
| slot0_tag | output | 16 | Tag word for slot 0 |

## Verification
Every frame output is due one clock edge after the cycle in which `frame_start` is driven high, and it stays constant until the next pulse. The bench drives all inputs on falling edges, raises `frame_start` for exactly one cycle, and compares the slot bus and the tag word at the next falling edge. In the hold test, the bench changes the code, the routing bit, the pins and the samples without a pulse. It then waits several cycles and checks that both outputs still equal the previous frame. A final boundary then shows the pending pair landing in the newly selected slots.

// File: rtl/acl_pkg.sv
// Package: shared constants, the placement-code type and the slot-pair
// lookup used by the capture slot assembler.
// Assumes slot 0 is the tag slot and slots 1..12 carry 20-bit data fields.
package acl_pkg;

    localparam int LAST_SLOT  = 12;
    localparam int GPIO_SLOT  = 12;
    localparam int DEF_SLOT_W = 20;
    localparam int TAG_W      = 16;

    typedef enum logic [1:0] {
        PAIR_S3_S4   = 2'b00,
        PAIR_S7_S8   = 2'b01,
        PAIR_S6_S9   = 2'b10,
        PAIR_S10_S11 = 2'b11
    } pair_code_e;

    // Slot number that receives the left sample for a placement code.
    function automatic int left_slot(pair_code_e c);
        case (c)
            PAIR_S3_S4:   return 3;
            PAIR_S7_S8:   return 7;
            PAIR_S6_S9:   return 6;
            default:      return 10;
        endcase
    endfunction

    // Slot number that receives the right sample for a placement code.
    function automatic int right_slot(pair_code_e c);
        case (c)
            PAIR_S3_S4:   return 4;
            PAIR_S7_S8:   return 8;
            PAIR_S6_S9:   return 9;
            default:      return 11;
        endcase
    endfunction

endpackage

// File: rtl/acl_slot_map.sv
// Module: acl_slot_map
// Decodes the 2-bit placement code into one-hot slot selects for the
// left and right samples. This is purely combinational.
// Assumes that no placement code selects the GPIO slot.
module acl_slot_map
    import acl_pkg::*;
(
    input  logic [1:0]         sel_code,
    output logic [LAST_SLOT:1] left_hot,
    output logic [LAST_SLOT:1] right_hot
);

    pair_code_e code;
    assign code = pair_code_e'(sel_code);

    for (genvar k = 1; k <= LAST_SLOT; k++) begin : g_dec
        // One compare per slot for each channel.
        assign left_hot[k]  = (left_slot(code)  == k);
        assign right_hot[k] = (right_slot(code) == k);
    end

    // Left and right never share a slot, and neither lands on slot 12.
    always_comb begin
        a_r6_map_disjoint: assert ((left_hot & right_hot) == '0 &&
                                   !left_hot[GPIO_SLOT] && !right_hot[GPIO_SLOT])
            else $error("slot map overlap");
    end

endmodule

// File: rtl/acl_sample_hold.sv
// Module: acl_sample_hold
// Holds the newest ADC sample pair until the next frame boundary. It
// forwards a pair that arrives in the boundary cycle itself.
// Assumes frame_start is a single-cycle pulse.
module acl_sample_hold #(
    parameter int SMP_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             smp_valid,
    input  logic [SMP_W-1:0] smp_left,
    input  logic [SMP_W-1:0] smp_right,
    output logic             pair_have,
    output logic [SMP_W-1:0] pair_left,
    output logic [SMP_W-1:0] pair_right
);

    logic             pend_q;
    logic [SMP_W-1:0] left_q, right_q;

    // Capture the latest pair; the frame boundary consumes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= 1'b0;
            left_q  <= '0;
            right_q <= '0;
        end else if (frame_start) begin
            pend_q  <= 1'b0;
        end else if (smp_valid) begin
            pend_q  <= 1'b1;
            left_q  <= smp_left;
            right_q <= smp_right;
        end
    end

    // A pair presented in the boundary cycle takes precedence over the held one.
    always_comb begin
        pair_have  = smp_valid | pend_q;
        pair_left  = smp_valid ? smp_left  : left_q;
        pair_right = smp_valid ? smp_right : right_q;
    end

    // R11: a boundary always leaves nothing pending.
    a_r11_pending_consumed: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !pend_q)
        else $error("pending pair survived a frame boundary");

endmodule

// File: rtl/acl_frame_builder.sv
// Module: acl_frame_builder
// Registers the twelve data slots and their valid flags on each frame
// boundary. The sample pair goes to the decoded slots and the pin state
// to slot 12. Assumes SMP_W <= SLOT_W and GPIO_W <= SLOT_W.
// Samples are MSB-justified and pins are LSB-justified.
module acl_frame_builder
    import acl_pkg::*;
#(
    parameter int SLOT_W = DEF_SLOT_W,
    parameter int SMP_W  = 20,
    parameter int GPIO_W = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      frame_start,
    input  logic [LAST_SLOT:1]        left_hot,
    input  logic [LAST_SLOT:1]        right_hot,
    input  logic                      pair_have,
    input  logic [SMP_W-1:0]          pair_left,
    input  logic [SMP_W-1:0]          pair_right,
    input  logic                      gpio_en,
    input  logic [GPIO_W-1:0]         gpio_pins,
    output logic [LAST_SLOT*SLOT_W-1:0] slot_bus,
    output logic [LAST_SLOT:1]        slot_vld
);

    localparam int SMP_PAD  = SLOT_W - SMP_W;
    localparam int GPIO_PAD = SLOT_W - GPIO_W;

    logic [SLOT_W-1:0] left_ext, right_ext, gpio_ext;

    if (SMP_PAD == 0) begin : g_smp_full
        assign left_ext  = pair_left;
        assign right_ext = pair_right;
    end else begin : g_smp_pad
        assign left_ext  = {pair_left,  {SMP_PAD{1'b0}}};
        assign right_ext = {pair_right, {SMP_PAD{1'b0}}};
    end

    if (GPIO_PAD == 0) begin : g_gpio_full
        assign gpio_ext = gpio_pins;
    end else begin : g_gpio_pad
        assign gpio_ext = {{GPIO_PAD{1'b0}}, gpio_pins};
    end

    for (genvar k = 1; k <= LAST_SLOT; k++) begin : g_slot
        logic [SLOT_W-1:0] data_q;
        logic              vld_q;

        if (k == GPIO_SLOT) begin : g_gpio
            // Slot 12 loads the pin state, or zero when routing is off.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    data_q <= '0;
                    vld_q  <= 1'b0;
                end else if (frame_start) begin
                    data_q <= gpio_en ? gpio_ext : '0;
                    vld_q  <= gpio_en;
                end
            end
        end else begin : g_audio
            // An audio slot loads left, right or zero at the boundary.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    data_q <= '0;
                    vld_q  <= 1'b0;
                end else if (frame_start) begin
                    if (pair_have && left_hot[k]) begin
                        data_q <= left_ext;
                        vld_q  <= 1'b1;
                    end else if (pair_have && right_hot[k]) begin
                        data_q <= right_ext;
                        vld_q  <= 1'b1;
                    end else begin
                        data_q <= '0;
                        vld_q  <= 1'b0;
                    end
                end
            end
        end

        assign slot_bus[(k-1)*SLOT_W +: SLOT_W] = data_q;
        assign slot_vld[k] = vld_q;
    end

    // R1: a reset edge empties every slot flag.
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (slot_vld == '0 && slot_bus == '0))
        else $error("reset left slot content");

    // R9: no boundary means no change in the frame content.
    a_r9_hold_between_frames: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> ($stable(slot_bus) && $stable(slot_vld)))
        else $error("frame content changed without a boundary");

    // R7: a boundary with no fresh pair leaves the audio slots untagged.
    a_r7_no_pair_no_tag: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !pair_have) |=> ($countones(slot_vld[LAST_SLOT-1:1]) == 0))
        else $error("audio tag set without a fresh pair");

    // R2: the audio slots are tagged in pairs only.
    a_r2_pair_tag_count: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> ($countones(slot_vld[LAST_SLOT-1:1]) inside {0, 2}))
        else $error("audio tags not paired");

    // R8: routing off yields an empty, untagged slot 12.
    a_r8_gpio_off_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !gpio_en) |=>
            (slot_bus[(GPIO_SLOT-1)*SLOT_W +: SLOT_W] == '0 && !slot_vld[GPIO_SLOT]))
        else $error("slot 12 driven with routing off");

endmodule

// File: rtl/aclink_capture_assembler.sv
// Module: aclink_capture_assembler (top)
// Builds the parallel content of one AC-link input frame. It places the
// ADC pair into the selected slot pair and optional pin state into slot
// 12, and forms the slot-0 tag word. Assumes frame_start pulses once per
// frame and all inputs are synchronous to clk.
module aclink_capture_assembler
    import acl_pkg::*;
#(
    parameter int SLOT_W = DEF_SLOT_W,
    parameter int SMP_W  = 20,
    parameter int GPIO_W = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        frame_start,
    input  logic [1:0]                  pair_code,
    input  logic                        gpio_to_slot12,
    input  logic [GPIO_W-1:0]           gpio_pins,
    input  logic                        smp_valid,
    input  logic [SMP_W-1:0]            smp_left,
    input  logic [SMP_W-1:0]            smp_right,
    output logic [LAST_SLOT*SLOT_W-1:0] slot_bus,
    output logic [TAG_W-1:0]            slot0_tag
);

    localparam int TAG_LSB_USED = TAG_W - 1 - LAST_SLOT;

    logic [LAST_SLOT:1] left_hot, right_hot, slot_vld;
    logic               pair_have;
    logic [SMP_W-1:0]   pair_left, pair_right;

    acl_slot_map u_map (
        .sel_code  (pair_code),
        .left_hot  (left_hot),
        .right_hot (right_hot)
    );

    acl_sample_hold #(.SMP_W(SMP_W)) u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .smp_valid   (smp_valid),
        .smp_left    (smp_left),
        .smp_right   (smp_right),
        .pair_have   (pair_have),
        .pair_left   (pair_left),
        .pair_right  (pair_right)
    );

    acl_frame_builder #(.SLOT_W(SLOT_W), .SMP_W(SMP_W), .GPIO_W(GPIO_W)) u_build (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .left_hot    (left_hot),
        .right_hot   (right_hot),
        .pair_have   (pair_have),
        .pair_left   (pair_left),
        .pair_right  (pair_right),
        .gpio_en     (gpio_to_slot12),
        .gpio_pins   (gpio_pins),
        .slot_bus    (slot_bus),
        .slot_vld    (slot_vld)
    );

    // Pack the slot-0 tag: frame flag on top, one flag per slot below it.
    always_comb begin
        slot0_tag = '0;
        slot0_tag[TAG_W-1] = |slot_vld;
        for (int k = 1; k <= LAST_SLOT; k++) begin
            slot0_tag[TAG_W-1-k] = slot_vld[k];
        end
    end

    // R10: the tag bits below the slot-12 flag never rise.
    a_r10_tag_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (slot0_tag[TAG_LSB_USED-1:0] == '0))
        else $error("reserved tag bits set");

endmodule

// File: tb/aclink_capture_assembler_test.sv
`timescale 1ns/1ps
module aclink_capture_assembler_test;

    localparam int SW = 20;
    localparam int BUS_W = 12 * SW;
    localparam int NVEC = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              frame_start = 1'b0;
    logic [1:0]        pair_code = 2'b00;
    logic              gpio_to_slot12 = 1'b0;
    logic [1:0]        gpio_pins = 2'b00;
    logic              smp_valid = 1'b0;
    logic [19:0]       smp_left = '0;
    logic [19:0]       smp_right = '0;
    logic [BUS_W-1:0]  slot_bus;
    logic [15:0]       slot0_tag;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    aclink_capture_assembler uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .frame_start    (frame_start),
        .pair_code      (pair_code),
        .gpio_to_slot12 (gpio_to_slot12),
        .gpio_pins      (gpio_pins),
        .smp_valid      (smp_valid),
        .smp_left       (smp_left),
        .smp_right      (smp_right),
        .slot_bus       (slot_bus),
        .slot0_tag      (slot0_tag)
    );

    // {code[45:44], route[43], pins[42:41], give[40], left[39:20], right[19:0]}
    localparam logic [45:0] VEC [NVEC] = '{
        {2'b00, 1'b0, 2'b00, 1'b1, 20'h12345, 20'hABCDE},
        {2'b01, 1'b1, 2'b10, 1'b1, 20'hFFFFF, 20'h00001},
        {2'b10, 1'b0, 2'b11, 1'b1, 20'h80000, 20'h7FFFF},
        {2'b11, 1'b1, 2'b01, 1'b1, 20'h5A5A5, 20'hA5A5A},
        {2'b00, 1'b1, 2'b11, 1'b1, 20'h00000, 20'hFFFFF},
        {2'b10, 1'b1, 2'b01, 1'b0, 20'h11111, 20'h22222},
        {2'b01, 1'b0, 2'b10, 1'b1, 20'hC0FFE, 20'h0BEEF},
        {2'b11, 1'b0, 2'b00, 1'b0, 20'h33333, 20'h44444}
    };

    function automatic int left_of(logic [1:0] c);
        case (c) 2'b00: return 3; 2'b01: return 7; 2'b10: return 6; default: return 10; endcase
    endfunction

    function automatic int right_of(logic [1:0] c);
        case (c) 2'b00: return 4; 2'b01: return 8; 2'b10: return 9; default: return 11; endcase
    endfunction

    function automatic logic [BUS_W-1:0] exp_bus(logic [1:0] c, logic rt, logic [1:0] g,
                                                  logic have, logic [19:0] l, logic [19:0] r);
        logic [BUS_W-1:0] b;
        b = '0;
        if (have) begin
            b[(left_of(c)-1)*SW +: SW]  = l;
            b[(right_of(c)-1)*SW +: SW] = r;
        end
        if (rt) b[11*SW +: SW] = {18'd0, g};
        return b;
    endfunction

    function automatic logic [15:0] exp_tag(logic [1:0] c, logic rt, logic have);
        logic [15:0] t;
        t = '0;
        if (have) begin
            t[15 - left_of(c)]  = 1'b1;
            t[15 - right_of(c)] = 1'b1;
        end
        if (rt) t[3] = 1'b1;
        t[15] = |t[14:3];
        return t;
    endfunction

    // OR of every slot that is neither in the pair nor routed slot 12
    function automatic logic [19:0] unused_or(logic [BUS_W-1:0] b, logic [1:0] c, logic rt);
        logic [19:0] acc;
        acc = '0;
        for (int k = 1; k <= 12; k++) begin
            if (k != left_of(c) && k != right_of(c) && !(k == 12 && rt))
                acc |= b[(k-1)*SW +: SW];
        end
        return acc;
    endfunction

    task automatic check(string req, logic [BUS_W-1:0] act, logic [BUS_W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One boundary pulse; outputs are then sampled at the next falling edge.
    task automatic boundary();
        @(negedge clk) frame_start = 1'b1;
        @(negedge clk) frame_start = 1'b0;
    endtask

    task automatic give_pair(logic [19:0] l, logic [19:0] r);
        @(negedge clk);
        smp_valid = 1'b1; smp_left = l; smp_right = r;
        @(negedge clk) smp_valid = 1'b0;
    endtask

    task automatic check_frame(string req, logic [1:0] c, logic rt, logic [1:0] g,
                               logic have, logic [19:0] l, logic [19:0] r);
        check(req, slot_bus, exp_bus(c, rt, g, have, l, r));
        check("R10 tag word", {224'd0, slot0_tag}, {224'd0, exp_tag(c, rt, have)});
        check("R6 unused slots zero", {220'd0, unused_or(slot_bus, c, rt)}, '0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [BUS_W-1:0] held_bus;
        logic [15:0]      held_tag;

        repeat (3) @(negedge clk);
        // R1: state after reset
        check("R1 reset bus", slot_bus, '0);
        check("R1 reset tag", {224'd0, slot0_tag}, '0);
        rst_n = 1'b1;

        // Vector table: R2..R5 placement, R7 no-pair frames, R8 routing
        for (int i = 0; i < NVEC; i++) begin
            logic [1:0]  c;
            logic        rt, gv;
            logic [1:0]  g;
            logic [19:0] l, r;
            string       req;
            {c, rt, g, gv, l, r} = VEC[i];
            @(negedge clk);
            pair_code = c; gpio_to_slot12 = rt; gpio_pins = g;
            if (gv) give_pair(l, r);
            boundary();
            case (c)
                2'b00: req = "R2 code 00";
                2'b01: req = "R3 code 01";
                2'b10: req = "R4 code 10";
                default: req = "R5 code 11";
            endcase
            if (!gv) req = {req, " R7 no pair"};
            if (rt) req = {req, " R8 pins on"}; else req = {req, " R8 pins off"};
            check_frame(req, c, rt, g, gv, l, r);
        end

        // R9: changes without a boundary leave the frame untouched
        @(negedge clk);
        pair_code = 2'b00; gpio_to_slot12 = 1'b0; gpio_pins = 2'b00;
        give_pair(20'h0F0F0, 20'hF0F0F);
        boundary();
        held_bus = slot_bus;
        held_tag = slot0_tag;
        @(negedge clk);
        pair_code = 2'b11; gpio_to_slot12 = 1'b1; gpio_pins = 2'b11;
        give_pair(20'h13579, 20'h2468A);
        repeat (4) @(negedge clk);
        check("R9 hold bus", slot_bus, held_bus);
        check("R9 hold tag", {224'd0, slot0_tag}, {224'd0, held_tag});
        boundary();
        check_frame("R9 pending lands at next boundary", 2'b11, 1'b1, 2'b11, 1'b1,
                    20'h13579, 20'h2468A);

        // R11: pair presented in the boundary cycle itself
        @(negedge clk);
        pair_code = 2'b10; gpio_to_slot12 = 1'b0;
        smp_valid = 1'b1; smp_left = 20'hDEAD1; smp_right = 20'hBEEF2;
        frame_start = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0; frame_start = 1'b0;
        check_frame("R11 same-cycle pair", 2'b10, 1'b0, 2'b00, 1'b1, 20'hDEAD1, 20'hBEEF2);

        // R11: last of several pairs wins
        give_pair(20'h11111, 20'h22222);
        give_pair(20'h99999, 20'h88888);
        boundary();
        check_frame("R11 newest pair", 2'b10, 1'b0, 2'b00, 1'b1, 20'h99999, 20'h88888);

        // R7: following frame with no new pair carries empty audio slots
        boundary();
        check_frame("R7 pair consumed", 2'b10, 1'b0, 2'b00, 1'b0, 20'h0, 20'h0);

        // R1: reset in mid-run clears a populated frame
        pair_code = 2'b01; gpio_to_slot12 = 1'b1; gpio_pins = 2'b01;
        give_pair(20'h77777, 20'h66666);
        boundary();
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        check("R1 mid-run reset bus", slot_bus, '0);
        check("R1 mid-run reset tag", {224'd0, slot0_tag}, '0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule